// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block produces the access addresses for a fixed-length burst in a synchronous memory. A load strobe captures a complete external address, latches the burst-order mode and clears the beat counter. After that, each advance request moves the burst forward by one beat. Only the low beat-index bits of the address change. The upper bits keep the loaded value until the next load.

Two orders are supported. In interleaved order, the low bits are the starting low bits XORed with the beat count. In linear order, the low bits are the starting low bits plus the beat count, wrapping modulo the burst length. If an edge carries no advance request, the burst is suspended and the address is held. After the last beat the beat counter wraps, and the same address cycle repeats until a new load.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is all zeros and beat_o is zero.
- R2: When load_i is high at a rising edge, addr_o equals the addr_i sampled at that edge and beat_o is zero in the following cycle.
- R3: Between loads, addr_o bits above the beat-index field (bit 2 and up with the default burst of 4) never change.
- R4: If mode_i was 1 at the load edge (interleaved), the low two bits of addr_o equal the starting low bits XOR beat_o. A start of 01 gives 01, 00, 11, 10.
- R5: If mode_i was 0 at the load edge (linear), the low two bits equal (start + beat_o) mod 4. A start of 10 gives 10, 11, 00, 01.
- R6: An edge with load_i low and adv_i low leaves addr_o and beat_o unchanged (suspend).
- R7: An edge with load_i low and adv_i high increments beat_o modulo 4. After beat 3 it returns to beat 0 and to the starting address.
- R8: load_i has priority over adv_i. An advance request on a load edge is ignored, and beat_o is 0 afterwards.
- R9: mode_i is used only at load edges. Changing mode_i in the middle of a burst does not alter the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe: capture addr_i and mode_i, clear the beat count |
| addr_i | input | ADDR_W | External start address |
| adv_i | input | 1 | Advance request: step to the next beat |
| mode_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_o | output | ADDR_W | Current access address |
| beat_o | output | BEAT_W | Current beat index |

## Verification
The bench builds the sequencer with ADDR_W = 12 and the default BURST_LEN = 4. With only twelve address bits, random start addresses cover every low-bit start value in both orders many times. Checks on the upper field can then compare full words cheaply. The four-beat burst puts the wrap from beat 3 to beat 0 within a few cycles, so random runs of advance, suspend and load often cross it. They also cross mid-burst mode flips and loads that collide with advance requests.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_INTLV  = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_o <= '0;
    else if (clr_i)   beat_o <= '0;
    else if (step_i)  beat_o <= beat_o + 1'b1; // natural wrap
  end
endmodule

// File: rtl/bseq_base_reg.sv
module bseq_base_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] base_o,
  output order_e            order_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o  <= '0;
      order_o <= ORD_INTLV;
    end else if (load_i) begin
      base_o  <= addr_i;
      order_o <= order_e'(mode_i);
    end
  end
endmodule

// File: rtl/bseq_low_map.sv
module bseq_low_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] low_xor, low_add;

  assign low_xor = start_i ^ beat_i;
  assign low_add = start_i + beat_i; // modulo 2**BEAT_W

  always_comb begin
    unique case (order_i)
      ORD_INTLV:  low_o = low_xor;
      default:    low_o = low_add;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4,
  localparam int BEAT_W   = $clog2(BURST_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_d;

  bseq_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .addr_i  (addr_i),
    .mode_i  (mode_i),
    .base_o  (base_q),
    .order_o (order_q)
  );

  // load wins over advance
  bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .step_i (adv_i & ~load_i),
    .beat_o (beat_q)
  );

  bseq_low_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat_q),
    .order_i (order_q),
    .low_o   (low_d)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_d};
  assign beat_o = beat_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BEAT_W-1:0] beat_o
);
  always_comb begin
    if (!rst_ni) begin
      AST_RESET_IDLE: assert (addr_o == '0 && beat_o == '0); // R1
    end
  end

  AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (addr_o == $past(addr_i) && beat_o == '0)); // R2

  AST_UPPER_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W])); // R3

  AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> ($stable(addr_o) && $stable(beat_o))); // R6

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> (beat_o == BEAT_W'($past(beat_o) + 1'b1))); // R7

  AST_LOAD_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && adv_i) |=> (beat_o == '0)); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .load_i (load_i),
  .addr_i (addr_i),
  .adv_i  (adv_i),
  .addr_o (addr_o),
  .beat_o (beat_o)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
  localparam int AW = 12;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adv = 1'b0;
  logic          mode = 1'b1;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] beat_q;

  int checks = 0;
  int errors = 0;

  // reference state from the requirements
  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_beat = '0;
  logic          m_mode = 1'b1;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u_burst_addr_seq (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (load),
    .addr_i (addr),
    .adv_i  (adv),
    .mode_i (mode),
    .addr_o (addr_q),
    .beat_o (beat_q)
  );

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [BW-1:0] bt, logic md);
    logic [BW-1:0] lo;
    lo = md ? (b[BW-1:0] ^ bt) : BW'(b[BW-1:0] + bt);
    return {b[AW-1:BW], lo};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, clock, update model, sample 2 ns after edge
  task automatic step(logic ld, logic [AW-1:0] a, logic av, logic md);
    @(negedge clk);
    load = ld; addr = a; adv = av; mode = md;
    @(posedge clk);
    if (ld) begin m_base = a; m_beat = '0; m_mode = md; end
    else if (av) m_beat = m_beat + 1'b1;
    #2;
  endtask

  task automatic chk_model(string tag);
    chk(tag, 32'(addr_q), 32'(exp_addr(m_base, m_beat, m_mode)));
    chk(tag, 32'(beat_q), 32'(m_beat));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    #12;
    chk("R1 reset addr", 32'(addr_q), 0);
    chk("R1 reset beat", 32'(beat_q), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4 interleaved, start 01
    step(1, 12'hA51, 0, 1);
    chk("R2 load addr", 32'(addr_q), 32'hA51);
    chk("R2 load beat", 32'(beat_q), 0);
    step(0, 12'h000, 1, 1); chk("R4 beat1", 32'(addr_q), 32'hA50);
    step(0, 12'h000, 1, 1); chk("R4 beat2", 32'(addr_q), 32'hA53);
    step(0, 12'h000, 0, 1); chk("R6 suspend", 32'(addr_q), 32'hA53);
    chk("R6 suspend beat", 32'(beat_q), 2);
    step(0, 12'h000, 1, 1); chk("R4 beat3", 32'(addr_q), 32'hA52);
    step(0, 12'h000, 1, 1); chk("R7 wrap addr", 32'(addr_q), 32'hA51);
    chk("R7 wrap beat", 32'(beat_q), 0);

    // R5 linear, start 10; mode flipped mid-burst (R9)
    step(1, 12'h3C6, 0, 0); chk("R2 load linear", 32'(addr_q), 32'h3C6);
    step(0, 12'hFFF, 1, 1); chk("R5 beat1", 32'(addr_q), 32'h3C7);
    step(0, 12'hFFF, 1, 0); chk("R5 beat2", 32'(addr_q), 32'h3C4);
    step(0, 12'hFFF, 1, 1); chk("R9 beat3 mode flip", 32'(addr_q), 32'h3C5);
    chk("R3 upper held", 32'(addr_q[AW-1:BW]), 32'(12'h3C6 >> 2));

    // R8 load with advance
    step(0, 12'h000, 1, 0);
    step(1, 12'h5E3, 1, 1);
    chk("R8 load prio addr", 32'(addr_q), 32'h5E3);
    chk("R8 load prio beat", 32'(beat_q), 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic ld, av, md;
      ld = ($urandom % 6) == 0;
      av = ($urandom % 3) != 0;
      md = $urandom % 2;
      step(ld, AW'($urandom), av, md);
      chk_model(ld ? "R2 R8 random load" : (av ? "R4 R5 R7 random step" : "R6 R9 random hold"));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule